// File: doc/BRIEF.md
# Interrupt Flag and Mask Register Unit

This unit gathers event pulses from several on-chip sources into one register of sticky flags. It holds an enable mask beside those flags and drives a single active-low interrupt request to the processor. Source 0 carries the first interval timer's underflow pulse and source 1 carries the second timer's. The remaining source inputs take any other single-cycle event, such as a serial shift completion. The unit does not contain the sources themselves.

The processor reaches the unit through one register address. A read strobe returns the flag byte, which also has a summary bit at the top, and clears the flags it returned. A write strobe updates the mask. The top data bit of a write selects whether the 1 bits in the low field switch their sources on or off. A static strap input decides whether the unit is allowed to pull the request line at all. When the strap is low, the flags and the summary bit still work, so software can poll them.

Top module: `icu_top`

## Requirements
- R1: While reset is asserted and right after it is released, `rdata_o` reads 0x00 (every flag clear, every mask bit clear) and `irq_n_o` is 1.
- R2: A 1 on `src_evt_i[i]` at a clock edge sets flag i, and the flag shows in `rdata_o[i]` after that edge, whatever the mask holds. Bit 0 is the first timer and bit 1 is the second timer.
- R3: A set flag stays set from cycle to cycle until a read strobe clears it.
- R4: A clock edge with `rd_en_i` high clears exactly the flags that `rdata_o` showed before that edge. If a source event arrives on the same edge, its flag is set after the edge.
- R5: A write with `wdata_i[7]` = 1 sets each mask bit i for which `wdata_i[i]` = 1 and leaves the other mask bits unchanged. With no write, the mask does not change.
- R6: A write with `wdata_i[7]` = 0 clears each mask bit i for which `wdata_i[i]` = 1 and leaves the other mask bits unchanged.
- R7: `rdata_o[7]` is 1 exactly when some flag bit and the matching mask bit are both 1. The bits between the source field and bit 7 read 0. The strap has no effect on this byte.
- R8: With the strap high, `irq_n_o` is 0 after an edge exactly when some flag is set whose mask bit is also set. It returns to 1 after the clearing read, or after the mask write that removes the last such pair.
- R9: With the strap low at a clock edge, `irq_n_o` is 1 after that edge, even when flags and mask bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_irq_en_i | input | 1 | Static strap; 1 allows the unit to drive the request line |
| src_evt_i | input | SRC_W (5) | Single-cycle source event pulses; bit 0 first timer, bit 1 second timer |
| rd_en_i | input | 1 | Read strobe for the register; clears the returned flags |
| wr_en_i | input | 1 | Write strobe for the register; updates the mask |
| wdata_i | input | DATA_W (8) | Write data; bit 7 picks set (1) or clear (0), low bits pick the sources |
| rdata_o | output | DATA_W (8) | Flag byte; bit 7 is the summary of pending enabled flags |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The hardest case is a source pulse that lands on the same edge as the clearing read. A unit that clears first and sets second would lose that event for good, and a unit that clears the whole register would drop flags that arrived after the byte was sampled. Mask writes are exercised in both polarities with patterns that mix set and untouched bits. A design that decoded bit 7 the wrong way round, or overwrote the mask instead of merging into it, would change the summary bit and the request line in ways the bench sees. The strap is switched low while enabled flags are pending, to catch a request line that leaks through. Flags are also raised on masked sources, to catch flag logic that wrongly depends on the mask.

// File: rtl/icu_pkg.sv
package icu_pkg;

    // Meaning of the top write-data bit
    typedef enum logic {
        MASK_CLEAR = 1'b0,
        MASK_SET   = 1'b1
    } mask_op_e;

    // Fixed source positions that neighbouring timer logic relies on
    localparam int unsigned SRC_TIMER_A = 0;
    localparam int unsigned SRC_TIMER_B = 1;

endpackage

// File: rtl/icu_flag_bank.sv
module icu_flag_bank #(
    parameter int unsigned SRC_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SRC_W-1:0] evt_i,
    input  logic             clr_i,
    output logic [SRC_W-1:0] flag_o,
    output logic [SRC_W-1:0] flag_nxt_o
);

    typedef struct packed {
        logic [SRC_W-1:0] flag;
    } flag_state_t;

    flag_state_t      st_d, st_q;
    logic [SRC_W-1:0] bit_nxt;

    // Per-source next value: a new event wins over the clearing read
    for (genvar g = 0; g < SRC_W; g++) begin : g_bit
        always_comb begin
            bit_nxt[g] = evt_i[g] | (st_q.flag[g] & ~clr_i);
        end

        AST_EVT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
            evt_i[g] |=> flag_o[g]); // R2
        AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_o[g] && !clr_i) |=> flag_o[g]); // R3
        AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i && !evt_i[g]) |=> !flag_o[g]); // R4
    end

    always_comb begin
        st_d      = st_q;
        st_d.flag = bit_nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o     = st_q.flag;
    assign flag_nxt_o = st_d.flag;

endmodule

// File: rtl/icu_mask_reg.sv
module icu_mask_reg #(
    parameter int unsigned SRC_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic             op_bit_i,
    input  logic [SRC_W-1:0] sel_i,
    output logic [SRC_W-1:0] mask_o,
    output logic [SRC_W-1:0] mask_nxt_o
);

    import icu_pkg::*;

    typedef struct packed {
        logic [SRC_W-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;
    mask_op_e    op;

    assign op = mask_op_e'(op_bit_i);

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            unique case (op)
                MASK_SET:   st_d.mask = st_q.mask | sel_i;
                MASK_CLEAR: st_d.mask = st_q.mask & ~sel_i;
                default:    st_d.mask = st_q.mask;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o     = st_q.mask;
    assign mask_nxt_o = st_d.mask;

    for (genvar g = 0; g < SRC_W; g++) begin : g_chk
        AST_MASK_SET_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_i && op_bit_i && sel_i[g]) |=> mask_o[g]); // R5
        AST_MASK_CLR_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_i && !op_bit_i && sel_i[g]) |=> !mask_o[g]); // R6
        AST_MASK_KEEP_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_i && !sel_i[g]) |=> $stable(mask_o[g])); // R6
    end

    AST_MASK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(mask_o)); // R5

endmodule

// File: rtl/icu_irq_out.sv
module icu_irq_out #(
    parameter int unsigned SRC_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             strap_i,
    input  logic [SRC_W-1:0] flag_i,
    input  logic [SRC_W-1:0] mask_i,
    input  logic [SRC_W-1:0] flag_nxt_i,
    input  logic [SRC_W-1:0] mask_nxt_i,
    output logic             summary_o,
    output logic             irq_n_o
);

    typedef struct packed {
        logic irq_n;
    } irq_state_t;

    irq_state_t st_d, st_q;

    // Request register is loaded from the next-state pair, so it moves on
    // the same edge as the flags and mask it reflects.
    always_comb begin
        st_d       = st_q;
        st_d.irq_n = ~(strap_i & (|(flag_nxt_i & mask_nxt_i)));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{irq_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign summary_o = |(flag_i & mask_i);
    assign irq_n_o   = st_q.irq_n;

    AST_STRAP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strap_i |=> irq_n_o); // R9
    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_n_o |-> summary_o); // R8

endmodule

// File: rtl/icu_top.sv
module icu_top #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SRC_W  = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              strap_irq_en_i,
    input  logic [SRC_W-1:0]  src_evt_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_n_o
);

    localparam int unsigned OP_POS = DATA_W - 1;

    logic [SRC_W-1:0] flag_q, flag_nxt;
    logic [SRC_W-1:0] mask_q, mask_nxt;
    logic             summary;
    logic             unused_wdata;

    assign unused_wdata = ^wdata_i;

    icu_flag_bank #(.SRC_W(SRC_W)) u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_i      (src_evt_i),
        .clr_i      (rd_en_i),
        .flag_o     (flag_q),
        .flag_nxt_o (flag_nxt)
    );

    icu_mask_reg #(.SRC_W(SRC_W)) u_mask (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (wr_en_i),
        .op_bit_i   (wdata_i[OP_POS]),
        .sel_i      (wdata_i[SRC_W-1:0]),
        .mask_o     (mask_q),
        .mask_nxt_o (mask_nxt)
    );

    icu_irq_out #(.SRC_W(SRC_W)) u_irq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .strap_i    (strap_irq_en_i),
        .flag_i     (flag_q),
        .mask_i     (mask_q),
        .flag_nxt_i (flag_nxt),
        .mask_nxt_i (mask_nxt),
        .summary_o  (summary),
        .irq_n_o    (irq_n_o)
    );

    always_comb begin
        rdata_o              = '0;
        rdata_o[SRC_W-1:0]   = flag_q;
        rdata_o[OP_POS]      = summary;
    end

    initial begin
        AST_PARAM_FIT: assert (SRC_W < DATA_W); // R7
    end

    AST_SUMMARY_OFF_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && src_evt_i == '0) |=> !rdata_o[OP_POS]); // R7

endmodule

// File: tb/icu_top_tb_top.sv
module icu_top_tb_top;

    localparam int DATA_W = 8;
    localparam int SRC_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strap = 1'b1;
    logic [SRC_W-1:0]  evt = '0;
    logic              rd = 1'b0;
    logic              wr = 1'b0;
    logic [DATA_W-1:0] wd = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [SRC_W-1:0] m_flag = '0;
    logic [SRC_W-1:0] m_mask = '0;
    logic             m_irq_n = 1'b1;

    always #5 clk = ~clk;

    icu_top #(.DATA_W(DATA_W), .SRC_W(SRC_W)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .strap_irq_en_i (strap),
        .src_evt_i      (evt),
        .rd_en_i        (rd),
        .wr_en_i        (wr),
        .wdata_i        (wd),
        .rdata_o        (rdata),
        .irq_n_o        (irq_n)
    );

    function automatic logic [DATA_W-1:0] exp_byte(logic [SRC_W-1:0] f, logic [SRC_W-1:0] m);
        logic [DATA_W-1:0] b;
        b = '0;
        b[SRC_W-1:0] = f;
        b[DATA_W-1] = |(f & m);
        return b;
    endfunction

    function automatic logic [SRC_W-1:0] next_mask(logic [SRC_W-1:0] m, logic w, logic [DATA_W-1:0] d);
        if (!w) return m;
        if (d[DATA_W-1]) return m | d[SRC_W-1:0];
        return m & ~d[SRC_W-1:0];
    endfunction

    task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // One bus cycle: drive at the falling edge, model the rising edge, sample after it
    task automatic cycle(logic [SRC_W-1:0] e, logic r, logic w, logic [DATA_W-1:0] d,
                         string tag_b, string tag_i);
        @(negedge clk);
        evt = e; rd = r; wr = w; wd = d;
        @(posedge clk);
        m_flag  = e | (r ? '0 : m_flag);
        m_mask  = next_mask(m_mask, w, d);
        m_irq_n = ~(strap & (|(m_flag & m_mask)));
        #2;
        chk(tag_b, rdata, exp_byte(m_flag, m_mask));
        chk(tag_i, {7'd0, irq_n}, {7'd0, m_irq_n});
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", rdata, 8'h00);
        chk("R1", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", rdata, 8'h00);
        chk("R1", {7'd0, irq_n}, 8'h01);

        // Directed corner cases
        cycle(5'b00001, 0, 0, 8'h00, "R2", "R8");  // first timer, masked off
        chk("R2", rdata, 8'h01);
        cycle(5'b00010, 0, 0, 8'h00, "R2", "R8");  // second timer
        chk("R2", rdata, 8'h03);
        cycle(5'b00000, 0, 0, 8'h00, "R3", "R8");
        cycle(5'b00000, 0, 0, 8'h00, "R3", "R8");
        chk("R3", rdata, 8'h03);
        cycle(5'b00000, 0, 1, 8'h81, "R5", "R8");  // enable source 0
        chk("R7", rdata, 8'h83);
        chk("R8", {7'd0, irq_n}, 8'h00);
        cycle(5'b00000, 1, 0, 8'h00, "R4", "R8");  // clearing read
        chk("R4", rdata, 8'h00);
        chk("R8", {7'd0, irq_n}, 8'h01);
        cycle(5'b00001, 0, 0, 8'h00, "R2", "R8");
        cycle(5'b00001, 1, 0, 8'h00, "R4", "R8");  // event on the read edge
        chk("R4", rdata, 8'h81);
        cycle(5'b00010, 1, 0, 8'h00, "R4", "R8");  // read drops bit 0, event sets bit 1
        chk("R4", rdata, 8'h02);
        cycle(5'b00000, 0, 1, 8'h86, "R5", "R8");  // mask now 0x07
        chk("R7", rdata, 8'h82);
        chk("R8", {7'd0, irq_n}, 8'h00);
        cycle(5'b00000, 0, 1, 8'h02, "R6", "R8");  // clear bit 1, mask 0x05
        chk("R6", rdata, 8'h02);
        chk("R8", {7'd0, irq_n}, 8'h01);
        cycle(5'b00100, 0, 0, 8'h00, "R2", "R8");
        chk("R8", {7'd0, irq_n}, 8'h00);
        strap = 1'b0;
        cycle(5'b00000, 0, 0, 8'h00, "R7", "R9");
        chk("R9", {7'd0, irq_n}, 8'h01);
        chk("R7", rdata, 8'h86);
        cycle(5'b00000, 0, 0, 8'h00, "R9", "R9");  // idle keeps the mask
        strap = 1'b1;
        cycle(5'b00000, 0, 0, 8'h00, "R5", "R8");
        chk("R8", {7'd0, irq_n}, 8'h00);

        // Constrained random phase
        for (int blk = 0; blk < 12; blk++) begin
            strap = ($urandom % 4) != 0;
            for (int i = 0; i < 200; i++) begin
                logic [SRC_W-1:0] e;
                logic r, w;
                logic [DATA_W-1:0] d;
                for (int b = 0; b < SRC_W; b++) e[b] = ($urandom % 8) == 0;
                r = ($urandom % 6) == 0;
                w = ($urandom % 7) == 0;
                d = DATA_W'($urandom);
                cycle(e, r, w, d, "R4", strap ? "R8" : "R9");
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule